// File: doc/BRIEF.md
# Mode-Configurable Serial Shift/Counter Port

This unit holds a small data register that works in one of two ways, chosen by one bit of a 4-bit enable word. In shift mode it moves one place to the left on every instruction cycle, and the serial input enters at the bottom. In counter mode it counts down once for each falling transition seen on the serial input pin. The same enable word chooses what the serial-data output and the clock output carry. It also switches on the drivers of an 8-bit parallel port.

A processor core uses the unit through two operations. A load writes the enable word. An exchange swaps the data register with the accumulator and copies the carry bit into a one-bit clock latch. An instruction-cycle strobe, one clock wide, sets the pace of shifting and of the clock output. A separate active-low clear pin resets the unit, but only after it has been held low across three instruction cycles.

Top module: `ser_mode_port`

## Requirements
- R1: After the synchronous reset, the data register, the enable word and the clock latch are all zero. The outputs `so`, `sk` and `port_oe` are 0 and `acc_out` is 0.
- R2: When enable bit 0 is clear (shift mode), each `cyc_stb` shifts the register left by one place. The synchronized `si` value enters bit 0. `si` must be stable for at least two clocks before the strobe.
- R3: When enable bit 0 is set (counter mode), each falling transition of `si` decrements the register by one, and 0 wraps to 15. The decrement appears three clocks after the fall. Strobes do not change the register in this mode.
- R4: In counter mode, `so` equals enable bit 3, whatever the register holds.
- R5: In shift mode, `so` equals register bit 3 when enable bit 3 is set, and 0 when enable bit 3 is clear. Shifting carries on in both cases.
- R6: `acc_out` always shows the register. A one-clock `xchg` loads `acc_in` into the register and `carry_in` into the clock latch. An exchange takes priority over a shift or a decrement in the same clock.
- R7: In counter mode, `sk` equals the clock latch.
- R8: In shift mode, `sk` is the clock latch ANDed with a cycle clock. The cycle clock is high for the first CYC_CLKS/2 clocks after a strobe edge and low after that, including before the first strobe.
- R9: `port_oe` equals enable bit 2. Enable bit 1 has no effect on any output.
- R10: When `clr_n` is low while CLR_CYCLES (3) strobes occur, the register, the enable word and the latch are cleared from the next clock on. If fewer strobes occur while it is low, the unit is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One-clock pulse per instruction cycle |
| clr_n | input | 1 | Active-low unit clear, qualified over instruction cycles |
| en_ld | input | 1 | Load `en_din` into the enable word |
| en_din | input | 4 | New enable word: bit0 counter mode, bit1 unused, bit2 port drive, bit3 serial-out enable |
| xchg | input | 1 | Exchange register with accumulator, copy carry into latch |
| acc_in | input | W (4) | Accumulator value written on exchange |
| carry_in | input | 1 | Carry bit copied into the clock latch on exchange |
| si | input | 1 | Serial input / count pin (asynchronous) |
| acc_out | output | W (4) | Current register contents returned to the accumulator |
| so | output | 1 | Serial-data output |
| sk | output | 1 | Clock / flag output |
| port_oe | output | 1 | Drive enable of the 8-bit parallel port |

## Verification
After a load or an exchange, `so`, `sk`, `port_oe` and `acc_out` settle after the next rising edge, because they are decoded directly from registers. A shift needs `si` to be held for two clocks through the synchronizer, and it then lands on the strobe edge. A decrement shows three clock edges after `si` falls. A clear takes effect on the edge after the third qualifying strobe. The bench drives and samples on falling edges, and it waits at least these numbers of edges before it compares against its own model. During every instruction cycle it checks `sk` clock by clock.

// File: rtl/ser_mode_pkg.sv
package ser_mode_pkg;

    // Enable word; bit positions are architectural (bit0 mode, bit2 port, bit3 serial out)
    typedef struct packed {
        logic so_ena;      // bit 3
        logic port_drive;  // bit 2
        logic spare;       // bit 1, no function
        logic count_mode;  // bit 0
    } en_word_t;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_COUNT = 1'b1
    } port_mode_e;

    function automatic port_mode_e mode_of(en_word_t e);
        return e.count_mode ? MODE_COUNT : MODE_SHIFT;
    endfunction

    // Serial-data output selection
    function automatic logic so_select(en_word_t e, logic reg_msb);
        if (mode_of(e) == MODE_COUNT)
            return e.so_ena;
        return e.so_ena & reg_msb;
    endfunction

    // Clock output selection
    function automatic logic sk_select(en_word_t e, logic latch, logic phase_hi);
        if (mode_of(e) == MODE_COUNT)
            return latch;
        return latch & phase_hi;
    endfunction

endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    logic [STAGES-1:0] stg;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= stg[STAGES-1];
    end

    assign dout = stg[STAGES-1];
    assign fall = prev & ~stg[STAGES-1];

    // A fall pulse lasts exactly one clock
    p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/ser_cycle_timer.sv
module ser_cycle_timer #(
    parameter int CYC_CLKS   = 8,
    parameter int CLR_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_stb,
    input  logic clr_n,
    output logic cyc_hi,
    output logic unit_clr
);
    localparam int PH_W = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
    localparam int HALF = CYC_CLKS / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_CLKS - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
    localparam int CW = $clog2(CLR_CYCLES + 1);
    localparam logic [CW-1:0] CLR_MAX = CW'(CLR_CYCLES);

    logic [PH_W-1:0] phase;
    logic [CW-1:0]   clr_cnt;

    always_ff @(posedge clk) begin
        if (rst)                   phase <= PH_LAST;
        else if (cyc_stb)          phase <= '0;
        else if (phase != PH_LAST) phase <= phase + 1'b1;
    end

    assign cyc_hi = (phase < PH_HALF);

    always_ff @(posedge clk) begin
        if (rst || clr_n)                         clr_cnt <= '0;
        else if (cyc_stb && clr_cnt != CLR_MAX)   clr_cnt <= clr_cnt + 1'b1;
    end

    assign unit_clr = (clr_cnt == CLR_MAX);

    p_phase_start_r8: assert property (@(posedge clk) disable iff (rst)
        cyc_stb |=> cyc_hi);

    p_clr_after_low_r10: assert property (@(posedge clk) disable iff (rst)
        unit_clr |-> $past(!clr_n));

endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
    import ser_mode_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         cyc_stb,
    input  logic         en_ld,
    input  logic [3:0]   en_din,
    input  logic         xchg,
    input  logic [W-1:0] acc_in,
    input  logic         carry_in,
    input  logic         sdata,
    input  logic         fall,
    output logic [W-1:0] q,
    output en_word_t     en,
    output logic         skl
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            en  <= '0;
            q   <= '0;
            skl <= 1'b0;
        end else begin
            if (en_ld) en <= en_word_t'(en_din);
            if (xchg) begin
                q   <= acc_in;
                skl <= carry_in;
            end else if (mode_of(en) == MODE_COUNT) begin
                if (fall) q <= q - 1'b1;
            end else if (cyc_stb) begin
                q <= {q[W-2:0], sdata};
            end
        end
    end

    p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!en.count_mode && cyc_stb && !xchg && !clear)
        |=> q == {$past(q[W-2:0]), $past(sdata)});

    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (en.count_mode && fall && !xchg && !clear) |=> q == $past(q) - 1'b1);

    p_count_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (en.count_mode && !fall && !xchg && !clear) |=> $stable(q));

    p_xchg_load_r6: assert property (@(posedge clk) disable iff (rst)
        (xchg && !clear) |=> (q == $past(acc_in)) && (skl == $past(carry_in)));

    p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (q == '0) && (en == '0) && !skl);

endmodule

// File: rtl/ser_mode_port.sv
module ser_mode_port
    import ser_mode_pkg::*;
#(
    parameter int W          = 4,
    parameter int SYNC_STG   = 2,
    parameter int CYC_CLKS   = 8,
    parameter int CLR_CYCLES = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cyc_stb,
    input  logic         clr_n,
    input  logic         en_ld,
    input  logic [3:0]   en_din,
    input  logic         xchg,
    input  logic [W-1:0] acc_in,
    input  logic         carry_in,
    input  logic         si,
    output logic [W-1:0] acc_out,
    output logic         so,
    output logic         sk,
    output logic         port_oe
);
    logic     s_bit, s_fall, cyc_hi, unit_clr, skl;
    logic [W-1:0] q;
    en_word_t en;

    ser_edge_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk (clk), .rst (rst), .din (si), .dout (s_bit), .fall (s_fall)
    );

    ser_cycle_timer #(.CYC_CLKS(CYC_CLKS), .CLR_CYCLES(CLR_CYCLES)) u_timer (
        .clk (clk), .rst (rst), .cyc_stb (cyc_stb), .clr_n (clr_n),
        .cyc_hi (cyc_hi), .unit_clr (unit_clr)
    );

    ser_shift_core #(.W(W)) u_core (
        .clk (clk), .rst (rst), .clear (unit_clr), .cyc_stb (cyc_stb),
        .en_ld (en_ld), .en_din (en_din), .xchg (xchg), .acc_in (acc_in),
        .carry_in (carry_in), .sdata (s_bit), .fall (s_fall),
        .q (q), .en (en), .skl (skl)
    );

    assign acc_out = q;
    assign so      = so_select(en, q[W-1]);
    assign sk      = sk_select(en, skl, cyc_hi);
    assign port_oe = en.port_drive;

    p_port_oe_load_r9: assert property (@(posedge clk) disable iff (rst)
        (en_ld && !unit_clr) |=> port_oe == $past(en_din[2]));

    p_so_count_r4: assert property (@(posedge clk) disable iff (rst)
        (en_ld && en_din[0] && !unit_clr) |=> so == $past(en_din[3]));

    p_sk_count_r7: assert property (@(posedge clk) disable iff (rst)
        (en_ld && en_din[0] && xchg && !unit_clr) |=> sk == $past(carry_in));

endmodule

// File: tb/ser_mode_port_bench.sv
module ser_mode_port_bench;
    localparam int CYC = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_stb = 1'b0, clr_n = 1'b1, en_ld = 1'b0, xchg = 1'b0;
    logic       carry_in = 1'b0, si = 1'b0;
    logic [3:0] en_din = '0, acc_in = '0;
    logic [3:0] acc_out;
    logic       so, sk, port_oe;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [3:0] m_q = '0, m_en = '0;
    logic       m_skl = 1'b0;

    always #4 clk = ~clk;

    ser_mode_port #(.CYC_CLKS(CYC)) u_ser_mode_port (
        .clk (clk), .rst (rst), .cyc_stb (cyc_stb), .clr_n (clr_n),
        .en_ld (en_ld), .en_din (en_din), .xchg (xchg), .acc_in (acc_in),
        .carry_in (carry_in), .si (si), .acc_out (acc_out), .so (so),
        .sk (sk), .port_oe (port_oe)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    function automatic logic exp_so();
        return m_en[0] ? m_en[3] : (m_en[3] & m_q[3]);
    endfunction

    // outputs at an idle point (cycle clock low)
    task automatic check_outs();
        chk("R6 acc_out", 32'(acc_out), 32'(m_q));
        chk(m_en[0] ? "R4 so" : "R5 so", 32'(so), 32'(exp_so()));
        chk(m_en[0] ? "R7 sk" : "R8 sk idle", 32'(sk), 32'(m_en[0] ? m_skl : 1'b0));
        chk("R9 port_oe", 32'(port_oe), 32'(m_en[2]));
    endtask

    task automatic load_en(input logic [3:0] v);
        @(negedge clk); en_ld = 1'b1; en_din = v;
        @(negedge clk); en_ld = 1'b0;
        m_en = v;
    endtask

    task automatic do_xchg(input logic [3:0] a, input logic c);
        @(negedge clk);
        chk("R6 read before exchange", 32'(acc_out), 32'(m_q));
        xchg = 1'b1; acc_in = a; carry_in = c;
        @(negedge clk); xchg = 1'b0;
        m_q = a; m_skl = c;
    endtask

    task automatic set_si(input logic b);
        @(negedge clk); si = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic instr_cycle();
        @(negedge clk); cyc_stb = 1'b1;
        if (!m_en[0]) m_q = {m_q[2:0], si};
        for (int i = 0; i < CYC; i++) begin
            @(negedge clk); cyc_stb = 1'b0;
            chk(m_en[0] ? "R7 sk cycle" : "R8 sk cycle", 32'(sk),
                32'(m_en[0] ? m_skl : (m_skl && i < CYC/2)));
        end
    endtask

    task automatic count_pulse();
        @(negedge clk); si = 1'b1;
        repeat (4) @(negedge clk);
        si = 1'b0;
        repeat (4) @(negedge clk);
        if (m_en[0]) m_q = m_q - 4'd1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 acc_out", 32'(acc_out), 32'h0);
        chk("R1 so", 32'(so), 32'h0);
        chk("R1 sk", 32'(sk), 32'h0);
        chk("R1 port_oe", 32'(port_oe), 32'h0);

        // R8 cycle clock shape, shift mode, latch set
        load_en(4'b0000);
        do_xchg(4'h0, 1'b1);
        check_outs();
        instr_cycle();
        check_outs();

        // R2 shift pattern 1,0,1,1 with R5 serial out enabled
        load_en(4'b1000);
        set_si(1'b1); instr_cycle(); check_outs();
        set_si(1'b0); instr_cycle(); check_outs();
        set_si(1'b1); instr_cycle(); check_outs();
        instr_cycle(); check_outs();
        chk("R2 shifted pattern", 32'(acc_out), 32'hB);
        set_si(1'b0);
        // R5 serial out disabled keeps so low while shifting continues
        load_en(4'b0000);
        instr_cycle(); check_outs();
        chk("R5 so held low", 32'(so), 32'h0);
        load_en(4'b1000);
        check_outs();

        // R6 exchange wins over a shift in the same clock
        @(negedge clk); cyc_stb = 1'b1; xchg = 1'b1; acc_in = 4'h5; carry_in = 1'b0;
        @(negedge clk); cyc_stb = 1'b0; xchg = 1'b0;
        m_q = 4'h5; m_skl = 1'b0;
        chk("R6 exchange priority", 32'(acc_out), 32'h5);
        repeat (CYC) @(negedge clk);
        check_outs();

        // R3 counter mode, wrap through zero; R4 so = bit3; R7 sk = latch
        load_en(4'b0001);
        do_xchg(4'h2, 1'b1);
        count_pulse(); check_outs();
        count_pulse(); check_outs();
        count_pulse(); check_outs();
        chk("R3 wrap to 15", 32'(acc_out), 32'hF);
        instr_cycle();
        chk("R3 strobe ignored in counter mode", 32'(acc_out), 32'hF);
        load_en(4'b1001);
        check_outs();
        chk("R4 so follows bit3", 32'(so), 32'h1);
        chk("R7 sk equals latch", 32'(sk), 32'h1);

        // R9 bit2 drives port, bit1 inert
        load_en(4'b0100); check_outs();
        load_en(4'b0010); check_outs();
        chk("R9 bit1 no port drive", 32'(port_oe), 32'h0);
        set_si(1'b1); instr_cycle(); check_outs();
        set_si(1'b0);

        // R10 clear qualification
        load_en(4'b0101);
        do_xchg(4'h9, 1'b0);
        @(negedge clk); clr_n = 1'b0;
        instr_cycle(); instr_cycle();
        check_outs();
        chk("R10 short clear ignored", 32'(port_oe), 32'h1);
        instr_cycle();
        m_q = '0; m_en = '0; m_skl = 1'b0;
        @(negedge clk); clr_n = 1'b1;
        @(negedge clk);
        check_outs();
        chk("R10 cleared register", 32'(acc_out), 32'h0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: load_en(4'($urandom_range(0, 15)));
                1: do_xchg(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
                2: if (!m_en[0]) begin
                       set_si(1'($urandom_range(0, 1)));
                       instr_cycle();
                       set_si(1'b0);
                   end
                3: count_pulse();
                default: instr_cycle();
            endcase
            check_outs();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule